// File: doc/BRIEF.md
# Oversampled Gaussian Transmit Shaper

This block turns a one-bit transmit stream into a signed frequency-deviation word for a VCO modulator. The data bit is captured on every edge of the filter clock, which runs at six times the bit rate, so each transmitted bit occupies six consecutive samples. The six most recent samples, each read as +1 for a one and -1 for a zero, are weighted by a symmetric Gaussian-shaped set of eight-bit coefficients (BT = 0.5) whose sum is 128. The filtered value is then multiplied by a three-bit deviation code that selects one of eight factors between 60 % and 130 % of nominal.

The output word is in units of one 1280th of the nominal deviation, so a long run of ones at the 100 % setting yields exactly +1280, and the nominal peak corresponds to 400 kHz. The filter works only while both its enable and the transmit-mode input are high; at any other time the sample line is emptied and the output is held at zero with the valid strobe low.

Top module: `gauss_tx_shaper`

## Requirements
- R1: With the six most recent samples s0 (newest) to s5 (oldest), each +1 for a data one and -1 for a data zero, and weights 10, 24, 30, 30, 24, 10 for s0 to s5, the output word equals (6 + devCode) times the weighted sum.
- R2: A constant stream of ones with devCode = 4 (100 %) produces +1280; a constant stream of zeros produces -1280.
- R3: devCode values 0 to 7 scale the output by 6, 7, 8, 9, 10, 11, 12 and 13 tenths of nominal, so a constant stream of ones yields 768, 896, 1024, 1152, 1280, 1408, 1536, 1664.
- R4: The result for the window completed by the sample captured at clock edge n appears on devWord, with devValid high, after edge n+2; one result follows each captured sample.
- R5: The shaper takes one sample on every clock edge while active, so a data bit held for six clocks fills the whole window.
- R6: The shaper is active only when filtEnable and txMode are both 1; after any edge at which it is inactive, devWord is 0 and devValid is 0, whatever txBit does.
- R7: An inactive edge empties the sample window: after the shaper becomes active again, devValid stays low until six new samples are captured, and the first result appears two edges after the sixth.
- R8: devWord is 0 whenever devValid is 0.
- R9: The magnitude of devWord never exceeds 1664.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Filter clock, six cycles per data bit |
| rst_n | input | 1 | Active-low synchronous reset |
| txBit | input | 1 | Transmit data bit, sampled every active edge |
| filtEnable | input | 1 | Filter enable setting (1 = on) |
| txMode | input | 1 | High while the radio is transmitting |
| devCode | input | CODE_W (3) | Deviation scale select, 60 % to 130 % |
| devWord | output | OUT_W (12) | Signed deviation word, 1280 = nominal |
| devValid | output | 1 | High when devWord carries a filtered result |

## Verification
The bench aims at the window-fill edge: a design that raises devValid one edge early, or that keeps stale samples across a disable, produces a result the scoreboard has no entry for, while one that raises it late leaves the wrong number of pending entries when the stream stops. Constant streams at every deviation code expose a wrong coefficient sum or scale table, since 128 times each factor must appear exactly, including the 1664 extreme. Per-sample irregular patterns catch swapped or asymmetric taps, and toggling txBit while the enable or the transmit mode is low shows whether an idle shaper still leaks samples or output.

// File: rtl/gauss_tx_pkg.sv
package gauss_tx_pkg;

  localparam int TAPS       = 6;   // window length in samples
  localparam int SCALE_BASE = 6;   // code 0 means 6 tenths of nominal

  // control-to-datapath strobes
  typedef struct packed {
    logic step;     // take a sample and advance the pipeline
    logic flush;    // empty the window and zero the output
    logic loadOut;  // the registered sum covers a full window
  } gfStrobe_t;

  // symmetric Gaussian-shaped weights, total 128
  function automatic int tapCoef(input int k);
    int m;
    m = (k < TAPS - 1 - k) ? k : TAPS - 1 - k;
    case (m)
      0:       return 10;
      1:       return 24;
      default: return 30;
    endcase
  endfunction

  function automatic int coefTotal();
    int s;
    s = 0;
    for (int k = 0; k < TAPS; k++) s += tapCoef(k);
    return s;
  endfunction

endpackage

// File: rtl/gauss_tx_ctrl.sv
module gauss_tx_ctrl
  import gauss_tx_pkg::*;
#(
  parameter int NTAPS = TAPS
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      filtEnable,
  input  logic      txMode,
  output gfStrobe_t strb,
  output logic      devValid
);

  localparam int CNT_W = $clog2(NTAPS + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(NTAPS);

  logic             active;
  logic [CNT_W-1:0] fillCnt;
  logic             sumLive;
  logic             outLive;

  assign active = filtEnable & txMode;

  always_ff @(posedge clk) begin
    if (!rst_n || !active) begin
      fillCnt <= '0;
      sumLive <= 1'b0;
      outLive <= 1'b0;
    end else begin
      if (fillCnt != FULL) fillCnt <= fillCnt + 1'b1;
      sumLive <= (fillCnt == FULL);
      outLive <= sumLive;
    end
  end

  always_comb begin
    strb.step    = active;
    strb.flush   = ~active;
    strb.loadOut = sumLive;
  end

  assign devValid = outLive;

  // R6: an inactive edge drops the valid strobe
  a_r6_idle_drops_valid: assert property (@(posedge clk) disable iff (!rst_n)
    !(filtEnable && txMode) |=> !devValid);

  // R7: a live sum only ever follows a completely refilled window
  a_r7_live_needs_full: assert property (@(posedge clk) disable iff (!rst_n)
    sumLive |-> fillCnt == FULL);

endmodule

// File: rtl/gauss_tx_dp.sv
module gauss_tx_dp
  import gauss_tx_pkg::*;
#(
  parameter int NTAPS  = TAPS,
  parameter int CODE_W = 3,
  parameter int SUM_W  = 9,
  parameter int OUT_W  = 12
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  gfStrobe_t               strb,
  input  logic                    txBit,
  input  logic [CODE_W-1:0]       devCode,
  output logic signed [OUT_W-1:0] devWord
);

  localparam int SCL_W  = $clog2(SCALE_BASE + (1 << CODE_W)) + 1;
  localparam int PROD_W = SUM_W + SCL_W;

  logic [NTAPS-1:0]          tapBits;   // bit 0 is the newest sample
  logic signed [SUM_W-1:0]   term [NTAPS];
  logic signed [SUM_W-1:0]   firSum;
  logic signed [SUM_W-1:0]   sumReg;
  logic signed [SCL_W-1:0]   scaleVal;
  logic signed [PROD_W-1:0]  prod;

  generate
    for (genvar k = 0; k < NTAPS; k++) begin : g_tap
      localparam logic signed [SUM_W-1:0] C = SUM_W'(tapCoef(k));
      assign term[k] = tapBits[k] ? C : -C;
    end
  endgenerate

  always_comb begin
    firSum = '0;
    for (int k = 0; k < NTAPS; k++) firSum = firSum + term[k];
  end

  assign scaleVal = SCL_W'(SCALE_BASE) + SCL_W'(devCode);
  assign prod     = PROD_W'(sumReg) * PROD_W'(scaleVal);

  always_ff @(posedge clk) begin
    if (!rst_n || strb.flush) begin
      tapBits <= '0;
      sumReg  <= '0;
      devWord <= '0;
    end else if (strb.step) begin
      tapBits <= {tapBits[NTAPS-2:0], txBit};
      sumReg  <= firSum;
      devWord <= strb.loadOut ? prod[OUT_W-1:0] : '0;
    end
  end

  // R6: a flush edge leaves a zero word
  a_r6_flush_zero: assert property (@(posedge clk) disable iff (!rst_n)
    strb.flush |=> devWord == '0);

  // R8: a step without a full window loads zero
  a_r8_partial_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.step && !strb.loadOut) |=> devWord == '0);

endmodule

// File: rtl/gauss_tx_shaper.sv
module gauss_tx_shaper
  import gauss_tx_pkg::*;
#(
  parameter int CODE_W = 3,
  parameter int SUM_W  = $clog2(coefTotal() + 1) + 1,
  parameter int OUT_W  = $clog2(coefTotal() * (SCALE_BASE + (1 << CODE_W) - 1) + 1) + 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    txBit,
  input  logic                    filtEnable,
  input  logic                    txMode,
  input  logic [CODE_W-1:0]       devCode,
  output logic signed [OUT_W-1:0] devWord,
  output logic                    devValid
);

  localparam int MAX_MAG = coefTotal() * (SCALE_BASE + (1 << CODE_W) - 1);

  gfStrobe_t strb;

  gauss_tx_ctrl #(.NTAPS(TAPS)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .filtEnable (filtEnable),
    .txMode     (txMode),
    .strb       (strb),
    .devValid   (devValid)
  );

  gauss_tx_dp #(
    .NTAPS  (TAPS),
    .CODE_W (CODE_W),
    .SUM_W  (SUM_W),
    .OUT_W  (OUT_W)
  ) u_dp (
    .clk     (clk),
    .rst_n   (rst_n),
    .strb    (strb),
    .txBit   (txBit),
    .devCode (devCode),
    .devWord (devWord)
  );

  // R8: no word leaks out while the strobe is low
  a_r8_quiet_word: assert property (@(posedge clk) disable iff (!rst_n)
    !devValid |-> devWord == '0);

  // R9: output stays within the largest scaled deviation
  a_r9_range: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(devWord) <= MAX_MAG) && (int'(devWord) >= -MAX_MAG));

endmodule

// File: tb/test_gauss_tx_shaper.sv
module test_gauss_tx_shaper;

  localparam int CLK_PERIOD = 10;

  typedef struct { int v; string req; } item_t;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              txBit = 1'b0;
  logic              filtEnable = 1'b0;
  logic              txMode = 1'b0;
  logic [2:0]        devCode = 3'd4;
  logic signed [11:0] devWord;
  logic              devValid;

  int     nChecks = 0;
  int     nFails  = 0;
  bit     done    = 1'b0;
  item_t  expQ[$];
  int     samples = 0;
  logic [5:0] hist = '0;
  bit [1:0]   pushFlags = '0;
  string  curReq = "R1";

  gauss_tx_shaper i_gauss_tx_shaper (
    .clk(clk), .rst_n(rst_n), .txBit(txBit), .filtEnable(filtEnable),
    .txMode(txMode), .devCode(devCode), .devWord(devWord), .devValid(devValid)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int expOf(input logic [5:0] h, input int code);
    int c [6] = '{10, 24, 30, 30, 24, 10};
    int s = 0;
    for (int k = 0; k < 6; k++) s += h[k] ? c[k] : -c[k];
    return s * (6 + code);
  endfunction

  // monitor: pops one expected item per valid cycle (R4), zero when idle (R8)
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (devValid) begin
        if (expQ.size() == 0) begin
          chk("R4 unexpected valid", 1, 0);
        end else begin
          item_t it;
          it = expQ.pop_front();
          chk(it.req, int'(devWord), it.v);
          if (devWord > 12'sd1664 || devWord < -12'sd1664) chk("R9 range", int'(devWord), 1664);
        end
      end else begin
        chk("R8 idle word", int'(devWord), 0);
      end
    end
  end

  // all tasks start and end at a falling edge
  task automatic activate(input int code, input string req);
    devCode = 3'(code); filtEnable = 1'b1; txMode = 1'b1; curReq = req;
  endtask

  task automatic pushSample(input logic b);
    bit pushed;
    txBit = b;
    @(posedge clk);
    hist = {hist[4:0], b};
    if (samples < 6) samples++;
    pushed = (samples == 6);
    if (pushed) expQ.push_back('{expOf(hist, int'(devCode)), curReq});
    pushFlags = {pushFlags[0], pushed};
    @(negedge clk);
  endtask

  task automatic pushBit(input logic b);   // R5: one data bit lasts six clocks
    repeat (6) pushSample(b);
  endtask

  task automatic quiesce(input logic en, input logic mode);
    filtEnable = en; txMode = mode;
    @(posedge clk);
    // R4: results from the last two samples are still in flight, none earlier
    chk("R4 pending results", expQ.size(), int'(pushFlags[0]) + int'(pushFlags[1]));
    expQ.delete();
    samples = 0; pushFlags = '0; hist = '0;
    @(negedge clk);
    chk("R6 valid after stop", int'(devValid), 0);
    chk("R6 word after stop", int'(devWord), 0);
  endtask

  task automatic idleNoise(input int n);
    repeat (n) begin
      txBit = ~txBit;
      @(posedge clk); @(negedge clk);
      chk("R6 ignored txBit valid", int'(devValid), 0);
      chk("R6 ignored txBit word", int'(devWord), 0);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      done = 1'b1;
      nChecks++; nFails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    logic [7:0] lfsr;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk("R6 reset valid", int'(devValid), 0);
    chk("R8 reset word", int'(devWord), 0);

    // R2: constant streams at nominal
    activate(4, "R2 ones nominal");
    repeat (12) pushSample(1'b1);
    quiesce(1'b0, 1'b1);
    activate(4, "R2 zeros nominal");
    repeat (12) pushSample(1'b0);
    quiesce(1'b0, 1'b1);

    // R1, R5: bit-rate pattern, each bit held six clocks
    activate(4, "R1 bit pattern");
    foreach (lfsr[i]) pushBit(1'(8'b1011_0010 >> i));
    quiesce(1'b0, 1'b1);

    // R3: every scale code with a constant one stream
    for (int c = 0; c < 8; c++) begin
      activate(c, "R3 scale code");
      repeat (8) pushSample(1'b1);
      quiesce(1'b0, 1'b1);
    end

    // R1: irregular per-sample stream at 70 %
    activate(1, "R1 sample stream");
    lfsr = 8'hA5;
    for (int i = 0; i < 40; i++) begin
      pushSample(lfsr[0]);
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    end
    // R6: enable low with transmit mode high
    quiesce(1'b0, 1'b1);
    idleNoise(8);

    // R6: transmit mode low with enable high
    filtEnable = 1'b1; txMode = 1'b0;
    idleNoise(8);

    // R7: single inactive edge mid-stream, then refill
    activate(5, "R7 refill");
    repeat (10) pushSample(1'b0);
    quiesce(1'b1, 1'b0);
    activate(5, "R7 refill");
    for (int i = 0; i < 7; i++) begin
      pushSample(1'(i % 2));
      if (i < 7) chk("R7 valid before refill", int'(devValid), int'(i >= 7));
    end
    pushSample(1'b1);
    chk("R7 first valid after refill", int'(devValid), 1);
    pushSample(1'b1);
    quiesce(1'b0, 1'b0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule